// File: doc/BRIEF.md
# Processor Performance Monitor Unit

A small counter unit that a processor core programs through a register bus. It holds one cycle counter and four event counters. Each event counter watches one bit of an event input bus. A per-counter event-type value picks that bit. The cycle counter advances on a cycle-tick input. It can also run divided by 64, so long intervals fit in its width.

Software controls the unit through a few registers. A control register holds the global run bit, the two one-shot clear actions and the divide mode. Two more control bits are stored only and have no effect. Enables are changed through two write-one registers, one that sets enable bits and one that clears them. Event counters are not mapped one by one. Software writes a counter index into a select register. The shared event-type and count registers then act on the counter that index chooses. The cycle counter has its own read/write register.

Top module: `pmu_core`

## Requirements
- R1: After reset every register reads zero, all counters are stopped, and addresses 7 to 15 always read zero.
- R2: The control register (address 0) keeps only its low 6 bits. Bit 0 is run, bit 3 is divide mode, and bits 4 and 5 are stored with no effect. Bits 1, 2 and 31:6 always read zero.
- R3: While control bit 0 is clear, no counter advances, whatever the event bus and the tick do.
- R4: Address 1 sets enables and address 2 clears them. Bit 31 is the cycle counter and bit n is event counter n. A 1 changes that enable and a 0 leaves it alone. Both addresses read back the current enable mask.
- R5: The select register (address 3, low 2 bits) picks the event counter. The event-type register (address 4, 8 bits) and the event-count register (address 5) read and write only the selected counter.
- R6: An event counter adds one on a clock when run is set, its enable is set, and event input bit [type] is high. A type of 16 or more never counts.
- R7: The cycle counter (address 6) adds one per tick while run and its enable are set, and can be read and written directly.
- R8: With control bit 3 set, the cycle counter adds one for every 64 qualifying ticks. A control write with bit 2 set restarts the divide phase, as does a write to address 6.
- R9: A control write with bit 1 set zeroes all event counters. A control write with bit 2 set zeroes the cycle counter. Neither bit is stored, and neither touches the other kind of counter.
- R10: A count-register write in the same cycle as an increment leaves the written value.
- R11: Counters wrap from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, same cycle |
| evt_in | input | 16 | Event input bus, one bit per event source |
| cyc_tick | input | 1 | Cycle tick for the cycle counter |

## Verification
Counter state can only be seen by reading it back through the bus. A wrong enable, select or type value therefore shows up one read later, as a count that is too high, too low or in the wrong counter. The counts in the tests are small and exact, so an increment that is off by one is caught. The divide phase is hidden. Its errors appear only at the 64th tick, so that boundary is checked on both sides. The priority between a clear, a write and an increment is checked by firing them in the same cycle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 4;
  localparam int CTRL_W  = 6;
  localparam int CYC_BIT = 31;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 4'd0,
    RA_ENSET = 4'd1,
    RA_ENCLR = 4'd2,
    RA_SEL   = 4'd3,
    RA_ETYPE = 4'd4,
    RA_ECNT  = 4'd5,
    RA_CCNT  = 4'd6
  } reg_addr_e;

  localparam int CB_RUN   = 0;
  localparam int CB_EVCLR = 1;
  localparam int CB_CYCLR = 2;
  localparam int CB_DIV   = 3;
endpackage

// File: rtl/pmu_rst_sync.sv
module pmu_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr #(
  parameter int CNT_W  = 32,
  parameter int EVT_W  = 16,
  parameter int TYPE_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              type_wr,
  input  logic              cnt_wr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              run,
  input  logic [EVT_W-1:0]  evt_in,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [TYPE_W-1:0] type_o
);
  localparam int IDX_W = (EVT_W > 1) ? $clog2(EVT_W) : 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TYPE_W-1:0] type_q;
  logic              in_range, hit, cnt_en;

  always_comb begin
    in_range = (type_q < TYPE_W'(EVT_W));
    hit      = in_range && evt_in[type_q[IDX_W-1:0]];
    cnt_en   = clr || cnt_wr || (run && hit);
    if (clr)         cnt_d = '0;
    else if (cnt_wr) cnt_d = wdata[CNT_W-1:0];
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      type_q <= '0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (type_wr) type_q <= wdata[TYPE_W-1:0];
    end
  end

  assign cnt_o  = cnt_q;
  assign type_o = type_q;
endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr #(
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             step,
  input  logic             div_mode,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [DIV_LOG2-1:0] div_q, div_d;
  logic                adv, cnt_en, div_en;

  always_comb begin
    adv    = step && (!div_mode || (&div_q));
    cnt_en = clr || wr || adv;
    div_en = clr || wr || (step && div_mode);
    if (clr)     cnt_d = '0;
    else if (wr) cnt_d = wdata;
    else         cnt_d = cnt_q + 1'b1;
    if (clr || wr) div_d = '0;
    else           div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (div_en) div_q <= div_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pmu_core.sv
module pmu_core
  import pmu_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int CNT_W    = 32,
  parameter int EVT_W    = 16,
  parameter int TYPE_W   = 8,
  parameter int DIV_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic              cyc_tick
);
  localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic rst_sn;
  pmu_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sn));

  logic wr_ctrl, wr_set, wr_clr, wr_sel, wr_etype, wr_ecnt, wr_ccnt;
  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == RA_CTRL);
    wr_set   = bus_wr && (bus_addr == RA_ENSET);
    wr_clr   = bus_wr && (bus_addr == RA_ENCLR);
    wr_sel   = bus_wr && (bus_addr == RA_SEL);
    wr_etype = bus_wr && (bus_addr == RA_ETYPE);
    wr_ecnt  = bus_wr && (bus_addr == RA_ECNT);
    wr_ccnt  = bus_wr && (bus_addr == RA_CCNT);
  end

  logic [CTRL_W-1:0]  ctrl_q, ctrl_d;
  logic [NUM_EVT-1:0] een_q, een_d;
  logic               cen_q, cen_d;
  logic [SEL_W-1:0]   sel_q;
  logic               en_wr, evt_clr, cyc_clr, glob_en;

  always_comb begin
    ctrl_d           = bus_wdata[CTRL_W-1:0];
    ctrl_d[CB_EVCLR] = 1'b0;
    ctrl_d[CB_CYCLR] = 1'b0;
    evt_clr = wr_ctrl && bus_wdata[CB_EVCLR];
    cyc_clr = wr_ctrl && bus_wdata[CB_CYCLR];
    en_wr   = wr_set || wr_clr;
    een_d   = een_q;
    cen_d   = cen_q;
    if (wr_set) begin
      een_d = een_q | bus_wdata[NUM_EVT-1:0];
      cen_d = cen_q | bus_wdata[CYC_BIT];
    end else if (wr_clr) begin
      een_d = een_q & ~bus_wdata[NUM_EVT-1:0];
      cen_d = cen_q & ~bus_wdata[CYC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q <= '0;
      een_q  <= '0;
      cen_q  <= 1'b0;
      sel_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (en_wr) begin
        een_q <= een_d;
        cen_q <= cen_d;
      end
      if (wr_sel) sel_q <= bus_wdata[SEL_W-1:0];
    end
  end

  assign glob_en = ctrl_q[CB_RUN];

  logic [CNT_W-1:0]         evt_cnt  [NUM_EVT];
  logic [TYPE_W-1:0]        evt_type [NUM_EVT];
  logic [NUM_EVT*CNT_W-1:0] evt_flat;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic hit_sel;
    assign hit_sel = (sel_q == SEL_W'(g));
    pmu_evt_ctr #(
      .CNT_W(CNT_W), .EVT_W(EVT_W), .TYPE_W(TYPE_W), .BUS_W(BUS_W)
    ) u_evt (
      .clk(clk), .rst_n(rst_sn), .clr(evt_clr),
      .type_wr(wr_etype && hit_sel), .cnt_wr(wr_ecnt && hit_sel),
      .wdata(bus_wdata), .run(glob_en && een_q[g]), .evt_in(evt_in),
      .cnt_o(evt_cnt[g]), .type_o(evt_type[g])
    );
    assign evt_flat[g*CNT_W +: CNT_W] = evt_cnt[g];
  end

  logic [CNT_W-1:0] cyc_cnt;
  pmu_cyc_ctr #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) u_cyc (
    .clk(clk), .rst_n(rst_sn), .clr(cyc_clr), .wr(wr_ccnt),
    .wdata(bus_wdata[CNT_W-1:0]), .step(glob_en && cen_q && cyc_tick),
    .div_mode(ctrl_q[CB_DIV]), .cnt_o(cyc_cnt)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
      RA_ENSET, RA_ENCLR: begin
        bus_rdata[NUM_EVT-1:0] = een_q;
        bus_rdata[CYC_BIT]     = cen_q;
      end
      RA_SEL:   bus_rdata[SEL_W-1:0]  = sel_q;
      RA_ETYPE: bus_rdata[TYPE_W-1:0] = evt_type[sel_q];
      RA_ECNT:  bus_rdata[CNT_W-1:0]  = evt_cnt[sel_q];
      RA_CCNT:  bus_rdata[CNT_W-1:0]  = cyc_cnt;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmu_core_chk.sv
module pmu_core_chk
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int CNT_W   = 32
) (
  input logic                     clk,
  input logic                     rst_sn,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_wr,
  input logic [BUS_W-1:0]         bus_wdata,
  input logic [BUS_W-1:0]         bus_rdata,
  input logic                     glob_en,
  input logic [CNT_W-1:0]         cyc_cnt,
  input logic [NUM_EVT*CNT_W-1:0] evt_flat
);
  logic ctrl_w, ccnt_w, ecnt_w;
  assign ctrl_w = bus_wr && (bus_addr == RA_CTRL);
  assign ccnt_w = bus_wr && (bus_addr == RA_CCNT);
  assign ecnt_w = bus_wr && (bus_addr == RA_ECNT);

  p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_addr == RA_CTRL) |-> (bus_rdata[31:6] == '0 && bus_rdata[2:1] == 2'b00));

  p_cyc_frozen_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!glob_en && !ctrl_w && !ccnt_w) |=> $stable(cyc_cnt));

  p_evt_frozen_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!glob_en && !ctrl_w && !ecnt_w) |=> $stable(evt_flat));

  p_cyc_step_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ctrl_w && !ccnt_w) |=>
      (cyc_cnt == $past(cyc_cnt) || cyc_cnt == $past(cyc_cnt) + 1'b1));

  p_evt_clear_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl_w && bus_wdata[CB_EVCLR]) |=> (evt_flat == '0));

  p_cyc_clear_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl_w && bus_wdata[CB_CYCLR]) |=> (cyc_cnt == '0));

  p_cyc_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    ccnt_w |=> (cyc_cnt == $past(bus_wdata[CNT_W-1:0])));
endmodule

bind pmu_core pmu_core_chk #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glob_en(glob_en),
  .cyc_cnt(cyc_cnt), .evt_flat(evt_flat)
);

// File: tb/pmu_core_tb.sv
module pmu_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 43;

  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [31:0] wd;
    logic [15:0] ev;
    logic        tk;
    logic        chk;
    logic [31:0] exp;
    logic [7:0]  rq;
  } vec_t;

  // Addresses: 0 ctrl, 1 enable set, 2 enable clear, 3 select, 4 type, 5 event count, 6 cycle count
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0, 32'h0, 16'h0, 1'b0, 1'b1, 32'h0, 8'd1},             // R1 ctrl after reset
    '{1'b0, 4'd7, 32'h0, 16'h0, 1'b0, 1'b1, 32'h0, 8'd1},             // R1 unmapped
    '{1'b1, 4'd0, 32'hFFFF_FF3F, 16'h0, 1'b0, 1'b0, 32'h0, 8'd2},
    '{1'b0, 4'd0, 32'h0, 16'h0, 1'b0, 1'b1, 32'h39, 8'd2},            // R2 stored bits
    '{1'b1, 4'd0, 32'h1, 16'h0, 1'b0, 1'b0, 32'h0, 8'd2},
    '{1'b1, 4'd1, 32'h8000_0005, 16'h0, 1'b0, 1'b0, 32'h0, 8'd4},
    '{1'b0, 4'd2, 32'h0, 16'h0, 1'b0, 1'b1, 32'h8000_0005, 8'd4},     // R4 mask via clear addr
    '{1'b1, 4'd2, 32'h4, 16'h0, 1'b0, 1'b0, 32'h0, 8'd4},
    '{1'b1, 4'd1, 32'h0, 16'h0, 1'b0, 1'b0, 32'h0, 8'd4},
    '{1'b0, 4'd1, 32'h0, 16'h0, 1'b0, 1'b1, 32'h8000_0001, 8'd4},     // R4 zero bits ignored
    '{1'b1, 4'd4, 32'h3, 16'h0, 1'b0, 1'b0, 32'h0, 8'd5},
    '{1'b0, 4'd0, 32'h0, 16'h0008, 1'b1, 1'b0, 32'h0, 8'd6},
    '{1'b0, 4'd0, 32'h0, 16'h0008, 1'b1, 1'b0, 32'h0, 8'd6},
    '{1'b0, 4'd0, 32'h0, 16'h0001, 1'b0, 1'b0, 32'h0, 8'd6},
    '{1'b0, 4'd5, 32'h0, 16'h0, 1'b0, 1'b1, 32'h2, 8'd6},             // R6 counted bit 3 only
    '{1'b0, 4'd6, 32'h0, 16'h0, 1'b0, 1'b1, 32'h2, 8'd7},             // R7 ticks
    '{1'b0, 4'd4, 32'h0, 16'h0, 1'b0, 1'b1, 32'h3, 8'd5},             // R5 type readback
    '{1'b1, 4'd3, 32'h1, 16'h0, 1'b0, 1'b0, 32'h0, 8'd5},
    '{1'b0, 4'd3, 32'h0, 16'h0, 1'b0, 1'b1, 32'h1, 8'd5},             // R5 select readback
    '{1'b1, 4'd4, 32'h5, 16'h0, 1'b0, 1'b0, 32'h0, 8'd5},
    '{1'b0, 4'd5, 32'h0, 16'h0, 1'b0, 1'b1, 32'h0, 8'd5},             // R5 counter 1 apart
    '{1'b1, 4'd3, 32'h0, 16'h0, 1'b0, 1'b0, 32'h0, 8'd5},
    '{1'b0, 4'd4, 32'h0, 16'h0, 1'b0, 1'b1, 32'h3, 8'd5},             // R5 counter 0 type kept
    '{1'b1, 4'd0, 32'h0, 16'h0, 1'b0, 1'b0, 32'h0, 8'd3},
    '{1'b0, 4'd0, 32'h0, 16'hFFFF, 1'b1, 1'b0, 32'h0, 8'd3},
    '{1'b0, 4'd5, 32'h0, 16'h0, 1'b0, 1'b1, 32'h2, 8'd3},             // R3 event frozen
    '{1'b0, 4'd6, 32'h0, 16'h0, 1'b0, 1'b1, 32'h2, 8'd3},             // R3 cycle frozen
    '{1'b1, 4'd0, 32'h1, 16'h0, 1'b0, 1'b0, 32'h0, 8'd3},
    '{1'b1, 4'd5, 32'h100, 16'h0008, 1'b0, 1'b0, 32'h0, 8'd10},
    '{1'b0, 4'd5, 32'h0, 16'h0, 1'b0, 1'b1, 32'h100, 8'd10},          // R10 write beats event
    '{1'b1, 4'd4, 32'h20, 16'h0, 1'b0, 1'b0, 32'h0, 8'd6},
    '{1'b0, 4'd0, 32'h0, 16'hFFFF, 1'b0, 1'b0, 32'h0, 8'd6},
    '{1'b0, 4'd5, 32'h0, 16'h0, 1'b0, 1'b1, 32'h100, 8'd6},           // R6 out-of-range type
    '{1'b1, 4'd0, 32'h3, 16'h0, 1'b0, 1'b0, 32'h0, 8'd9},
    '{1'b0, 4'd5, 32'h0, 16'h0, 1'b0, 1'b1, 32'h0, 8'd9},             // R9 event clear
    '{1'b0, 4'd6, 32'h0, 16'h0, 1'b0, 1'b1, 32'h2, 8'd9},             // R9 cycle untouched
    '{1'b0, 4'd0, 32'h0, 16'h0, 1'b0, 1'b1, 32'h1, 8'd9},             // R9 action bit not stored
    '{1'b1, 4'd0, 32'h5, 16'h0, 1'b0, 1'b0, 32'h0, 8'd9},
    '{1'b0, 4'd6, 32'h0, 16'h0, 1'b0, 1'b1, 32'h0, 8'd9},             // R9 cycle clear
    '{1'b1, 4'd6, 32'hFFFF_FFFE, 16'h0, 1'b0, 1'b0, 32'h0, 8'd7},
    '{1'b0, 4'd6, 32'h0, 16'h0, 1'b1, 1'b1, 32'hFFFF_FFFE, 8'd7},     // R7 direct write
    '{1'b0, 4'd6, 32'h0, 16'h0, 1'b1, 1'b1, 32'hFFFF_FFFF, 8'd11},
    '{1'b0, 4'd6, 32'h0, 16'h0, 1'b0, 1'b1, 32'h0, 8'd11}             // R11 wrap
  };

  logic        clk, rst_n, bus_wr, cyc_tick;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] evt_in;
  int total, bad;
  bit done;

  pmu_core u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .cyc_tick(cyc_tick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input logic wr, input logic [3:0] addr, input logic [31:0] wd,
                      input logic [15:0] ev, input logic tk, input logic chk,
                      input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_wr = wr; bus_addr = addr; bus_wdata = wd; evt_in = ev; cyc_tick = tk;
    #1;
    if (chk) begin
      total++;
      if (bus_rdata !== exp) begin
        bad++;
        $display("FAIL %s addr=%0d got=%h exp=%h", req, addr, bus_rdata, exp);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; evt_in = '0; cyc_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++)
      step(VEC[i].wr, VEC[i].addr, VEC[i].wd, VEC[i].ev, VEC[i].tk, VEC[i].chk,
           VEC[i].exp, $sformatf("R%0d", VEC[i].rq));

    // R8: divide by 64, phase restarted by the cycle-clear action
    step(1'b1, 4'd0, 32'hD, 16'h0, 1'b0, 1'b0, 32'h0, "R8");
    for (int k = 0; k < 63; k++) step(1'b0, 4'd6, 32'h0, 16'h0, 1'b1, 1'b0, 32'h0, "R8");
    step(1'b0, 4'd6, 32'h0, 16'h0, 1'b1, 1'b1, 32'h0, "R8");
    step(1'b0, 4'd6, 32'h0, 16'h0, 1'b0, 1'b1, 32'h1, "R8");
    for (int k = 0; k < 64; k++) step(1'b0, 4'd6, 32'h0, 16'h0, 1'b1, 1'b0, 32'h0, "R8");
    step(1'b0, 4'd6, 32'h0, 16'h0, 1'b0, 1'b1, 32'h2, "R8");

    // R10: cycle write together with a tick keeps the written value
    step(1'b1, 4'd0, 32'h1, 16'h0, 1'b0, 1'b0, 32'h0, "R10");
    step(1'b1, 4'd6, 32'h7, 16'h0, 1'b1, 1'b0, 32'h0, "R10");
    step(1'b0, 4'd6, 32'h0, 16'h0, 1'b0, 1'b1, 32'h7, "R10");

    // R1: reset in mid run returns everything to zero
    @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step(1'b0, 4'd0, 32'h0, 16'h0, 1'b0, 1'b1, 32'h0, "R1");
    step(1'b0, 4'd1, 32'h0, 16'h0, 1'b0, 1'b1, 32'h0, "R1");
    step(1'b0, 4'd6, 32'h0, 16'h0, 1'b0, 1'b1, 32'h0, "R1");
    step(1'b0, 4'd4, 32'h0, 16'h0, 1'b0, 1'b1, 32'h0, "R1");

    finish_run();
  end
endmodule